// File: doc/BRIEF.md
# Hot Key Detector With Sketch

This block watches every key query that crosses it and picks out keys that are not yet cached but have become popular. Each query comes in as a 64-bit key hash with a flag that says whether the key already has a cache slot. Uncached keys are counted in a count-min sketch. When a key's estimated count reaches a programmable threshold, its hash goes into a small report queue, and a controller reads that queue over a ready/valid handshake to decide on cache insertion. A Bloom filter remembers which keys have been reported, so each hot key is reported at most once per interval. Cached queries instead bump a per-slot hit counter, which is read combinationally through a slot-addressed read port.

A free-running interval timer starts a sweep that clears the sketch, the Bloom filter and the hit counters, one address per cycle. This keeps the counters narrow and lets popularity age out. There is no sampling stage, so every query is examined. Queries that arrive while a sweep is running are left out of the statistics, and the input is never stalled.

Top module: `hot_key_detector`

## Requirements
- R1: After reset, rpt_valid is 0, sweep_busy is 0 and every hit counter reads 0.
- R2: A query with q_valid=1 and q_cached=1 outside a sweep adds one to the hit counter of slot q_slot. The counter saturates at 65535. rd_count shows the counter of rd_slot in the same cycle, and other slots are left unchanged.
- R3: An uncached query outside a sweep adds one (saturating) to one 16-bit counter in each of 4 sketch rows. Row r is indexed by key bits [16r+9:16r]. The estimate is the smallest of the 4 updated counts, and the key is reported only if this estimate is at least threshold.
- R4: The Bloom filter has 4096 bits and probes 3 of them, at key bits [21:10], [37:26] and [53:42]. A report sets all 3 bits. A key whose 3 bits are all set is not reported again.
- R5: Reports leave through a 4-entry first-in first-out queue. rpt_valid and rpt_key stay stable until accepted with rpt_ready=1.
- R6: If a report arrives while the queue holds 4 entries, the report is dropped and its Bloom bits stay clear, so a later query of the same key can report it.
- R7: When clear_interval is nonzero, a sweep starts after clear_interval cycles with sweep_busy low. The sweep keeps sweep_busy high for 4096 cycles. A zero clear_interval starts no sweep.
- R8: Queries that arrive while sweep_busy is 1 change no counter, set no Bloom bit and produce no report.
- R9: After a sweep ends, every hit counter, sketch counter and Bloom bit is 0, so a previously reported key is reported again once it reaches threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | A query is present this cycle |
| q_key | input | 64 | Hash of the queried key |
| q_cached | input | 1 | Key already holds a cache slot |
| q_slot | input | 6 | Cache slot of a cached key |
| threshold | input | 16 | Estimated count at which a key is hot |
| clear_interval | input | 32 | Idle cycles between sweeps, 0 disables |
| rpt_valid | output | 1 | Report queue holds an entry |
| rpt_ready | input | 1 | Controller accepts the head report |
| rpt_key | output | 64 | Key hash at the head of the report queue |
| rd_slot | input | 6 | Slot whose hit counter is read |
| rd_count | output | 16 | Hit counter of rd_slot |
| sweep_busy | output | 1 | Clearing sweep in progress |

## Verification
The assertions assume that rpt_ready is only meaningful while rpt_valid is high. They also assume that threshold and clear_interval change only between scenarios, never in the middle of a key's counting. The bench changes these settings only while the queue is drained and no query is in flight. It turns the interval off during the hot-key scenarios, so no sweep can cut into them. Test keys are built from a repeated nibble, which places each key on distinct sketch columns and Bloom bits. The one exception is a key built to share a single sketch row with another, so that the minimum rule is exercised.

// File: rtl/hkd_pkg.sv
package hkd_pkg;
  localparam int LANE_W = 16;

  // Index of sketch row r: the low bits of 16-bit lane r of the hash.
  function automatic logic [63:0] row_field(input logic [63:0] key, input int r);
    return key >> (r * LANE_W);
  endfunction

  // Bloom probe k: starts 10 bits into lane k.
  function automatic logic [63:0] probe_field(input logic [63:0] key, input int k);
    return key >> (k * LANE_W + 10);
  endfunction
endpackage

// File: rtl/hkd_sketch.sv
module hkd_sketch #(
  parameter int KEY_W = 64,
  parameter int ROWS  = 4,
  parameter int AW    = 10,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic             upd_en,
  input  logic [KEY_W-1:0] key,
  output logic [CW-1:0]    est
);
  import hkd_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] nxt [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [CW-1:0] mem [DEPTH];
    logic [AW-1:0] idx;
    logic [CW-1:0] cur;
    logic [63:0]   fld;
    assign fld = row_field(64'(key), r);
    assign idx = fld[AW-1:0];
    assign cur = mem[idx];
    assign nxt[r] = (cur == '1) ? cur : cur + 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr_en) begin
        mem[clr_addr] <= '0;
      end else if (upd_en) begin
        mem[idx] <= nxt[r];
      end
    end
  end

  always_comb begin
    est = nxt[0];
    for (int r = 1; r < ROWS; r++)
      if (nxt[r] < est) est = nxt[r];
  end
endmodule

// File: rtl/hkd_bloom.sv
module hkd_bloom #(
  parameter int KEY_W  = 64,
  parameter int AW     = 12,
  parameter int PROBES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic             set_en,
  input  logic [KEY_W-1:0] key,
  output logic             all_set
);
  import hkd_pkg::*;
  localparam int BITS = 1 << AW;

  logic [BITS-1:0]   bits;
  logic [AW-1:0]     idx [PROBES];
  logic [PROBES-1:0] hit;

  for (genvar k = 0; k < PROBES; k++) begin : g_probe
    logic [63:0] fld;
    assign fld    = probe_field(64'(key), k);
    assign idx[k] = fld[AW-1:0];
    assign hit[k] = bits[idx[k]];
  end

  assign all_set = &hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (clr_en) begin
      bits[clr_addr] <= 1'b0;
    end else if (set_en) begin
      for (int k = 0; k < PROBES; k++) bits[idx[k]] <= 1'b1;
    end
  end
endmodule

// File: rtl/hkd_report_fifo.sv
module hkd_report_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    store [DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] level;
  logic            pop;

  assign full  = (level == CNTW'(DEPTH));
  assign valid = (level != '0);
  assign pop   = valid && ready;
  assign dout  = store[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push && !full) begin
        store[wr_ptr] <= din;
        wr_ptr <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      level <= level + CNTW'(push && !full) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/hkd_sweep_timer.sv
module hkd_sweep_timer #(
  parameter int TW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] interval,
  output logic          busy,
  output logic [AW-1:0] addr
);
  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      addr     <= '0;
      idle_cnt <= '0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == '1) begin
        busy     <= 1'b0;
        idle_cnt <= '0;
      end
    end else if (interval != '0 && idle_cnt >= interval - 1'b1) begin
      busy     <= 1'b1;
      addr     <= '0;
      idle_cnt <= '0;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hot_key_detector.sv
module hot_key_detector #(
  parameter int KEY_W     = 64,
  parameter int ROWS      = 4,
  parameter int COL_AW    = 10,
  parameter int CNT_W     = 16,
  parameter int BLOOM_AW  = 12,
  parameter int PROBES    = 3,
  parameter int SLOT_AW   = 6,
  parameter int HIT_W     = 16,
  parameter int TIMER_W   = 32,
  parameter int RPT_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_valid,
  input  logic [KEY_W-1:0]   q_key,
  input  logic               q_cached,
  input  logic [SLOT_AW-1:0] q_slot,
  input  logic [CNT_W-1:0]   threshold,
  input  logic [TIMER_W-1:0] clear_interval,
  output logic               rpt_valid,
  input  logic               rpt_ready,
  output logic [KEY_W-1:0]   rpt_key,
  input  logic [SLOT_AW-1:0] rd_slot,
  output logic [HIT_W-1:0]   rd_count,
  output logic               sweep_busy
);
  localparam int SWEEP_AW = (BLOOM_AW > COL_AW) ?
                            ((BLOOM_AW > SLOT_AW) ? BLOOM_AW : SLOT_AW) :
                            ((COL_AW > SLOT_AW) ? COL_AW : SLOT_AW);
  localparam int SLOTS = 1 << SLOT_AW;

  logic [SWEEP_AW-1:0] sweep_addr;
  logic                sk_upd, hit_upd;
  logic [CNT_W-1:0]    sk_est;
  logic                bloom_all_set;
  logic                rpt_want, rpt_push, fifo_full;
  logic [HIT_W-1:0]    hits [SLOTS];

  hkd_sweep_timer #(.TW(TIMER_W), .AW(SWEEP_AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(clear_interval),
    .busy(sweep_busy), .addr(sweep_addr)
  );

  assign sk_upd  = q_valid && !q_cached && !sweep_busy;
  assign hit_upd = q_valid &&  q_cached && !sweep_busy;

  hkd_sketch #(.KEY_W(KEY_W), .ROWS(ROWS), .AW(COL_AW), .CW(CNT_W)) u_sketch (
    .clk(clk), .rst_n(rst_n), .clr_en(sweep_busy),
    .clr_addr(sweep_addr[COL_AW-1:0]), .upd_en(sk_upd), .key(q_key), .est(sk_est)
  );

  assign rpt_want = sk_upd && (sk_est >= threshold) && !bloom_all_set;
  assign rpt_push = rpt_want && !fifo_full;

  hkd_bloom #(.KEY_W(KEY_W), .AW(BLOOM_AW), .PROBES(PROBES)) u_bloom (
    .clk(clk), .rst_n(rst_n), .clr_en(sweep_busy),
    .clr_addr(sweep_addr[BLOOM_AW-1:0]), .set_en(rpt_push), .key(q_key),
    .all_set(bloom_all_set)
  );

  hkd_report_fifo #(.W(KEY_W), .DEPTH(RPT_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rpt_want), .din(q_key), .full(fifo_full),
    .valid(rpt_valid), .ready(rpt_ready), .dout(rpt_key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) hits[i] <= '0;
    end else if (sweep_busy) begin
      hits[sweep_addr[SLOT_AW-1:0]] <= '0;
    end else if (hit_upd && hits[q_slot] != '1) begin
      hits[q_slot] <= hits[q_slot] + 1'b1;
    end
  end

  assign rd_count = hits[rd_slot];
endmodule

// File: rtl/hkd_checker.sv
module hkd_checker #(
  parameter int KEY_W = 64,
  parameter int CNT_W = 16,
  parameter int HIT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rpt_valid,
  input logic             rpt_ready,
  input logic [KEY_W-1:0] rpt_key,
  input logic             push,
  input logic             q_full,
  input logic             bloom_all,
  input logic [CNT_W-1:0] est,
  input logic [CNT_W-1:0] threshold,
  input logic             sweep_busy,
  input logic [HIT_W-1:0] rd_count
);
  // R3
  hot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> est >= threshold);

  // R4
  bloom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !bloom_all);

  // R5
  report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_key)));

  // R6
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !q_full);

  // R8
  sweep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !push);

  // R9
  swept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_busy) |-> rd_count == '0);
endmodule

bind hot_key_detector hkd_checker #(.KEY_W(KEY_W), .CNT_W(CNT_W), .HIT_W(HIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
  .rpt_key(rpt_key), .push(rpt_push), .q_full(fifo_full),
  .bloom_all(bloom_all_set), .est(sk_est), .threshold(threshold),
  .sweep_busy(sweep_busy), .rd_count(rd_count)
);

// File: tb/tb_hot_key_detector.sv
module tb_hot_key_detector;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        q_valid = 0;
  logic [63:0] q_key = '0;
  logic        q_cached = 0;
  logic [5:0]  q_slot = '0;
  logic [15:0] threshold = 16'd3;
  logic [31:0] clear_interval = '0;
  logic        rpt_valid, rpt_ready = 0;
  logic [63:0] rpt_key;
  logic [5:0]  rd_slot = '0;
  logic [15:0] rd_count;
  logic        sweep_busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hot_key_detector dut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_key(q_key),
    .q_cached(q_cached), .q_slot(q_slot), .threshold(threshold),
    .clear_interval(clear_interval), .rpt_valid(rpt_valid),
    .rpt_ready(rpt_ready), .rpt_key(rpt_key), .rd_slot(rd_slot),
    .rd_count(rd_count), .sweep_busy(sweep_busy)
  );

  function automatic logic [63:0] nkey(input logic [3:0] n);
    return {16{n}};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] k, input logic c, input logic [5:0] s);
    q_valid = 1; q_key = k; q_cached = c; q_slot = s;
    @(negedge clk);
    q_valid = 0;
  endtask

  task automatic pop();
    rpt_ready = 1;
    @(negedge clk);
    rpt_ready = 0;
  endtask

  function automatic logic [15:0] read_hits_now(input logic [5:0] s);
    return 16'(s);
  endfunction

  task automatic read_hits(input logic [5:0] s, output logic [15:0] v);
    rd_slot = s; #1; v = rd_count;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 rpt_valid", 64'(rpt_valid), 0);
    check("R1 sweep_busy", 64'(sweep_busy), 0);
    read_hits(6'd9, v);
    check("R1 hit counter", 64'(v), 0);
  endtask

  task automatic t_hits();
    logic [15:0] v;
    for (int i = 0; i < 3; i++) send(64'h0, 1, 6'd5);
    read_hits(6'd5, v);
    check("R2 slot 5 count", 64'(v), 3);
    read_hits(6'd6, v);
    check("R2 slot 6 untouched", 64'(v), 0);
  endtask

  task automatic t_hot();
    send(nkey(1), 0, 0);
    send(nkey(1), 0, 0);
    check("R3 below threshold", 64'(rpt_valid), 0);
    send(nkey(1), 0, 0);
    check("R3 reported at threshold", 64'(rpt_valid), 1);
    check("R3 reported key", rpt_key, nkey(1));
    pop();
    send(nkey(1), 0, 0);
    check("R4 no second report", 64'(rpt_valid), 0);
    // shares only sketch row 0 with key 1
    send({48'h2222_2222_2222, 16'h1111}, 0, 0);
    check("R3 minimum across rows", 64'(rpt_valid), 0);
  endtask

  task automatic t_queue();
    for (int n = 3; n <= 7; n++)
      for (int j = 0; j < 3; j++) send(nkey(4'(n)), 0, 0);
    for (int n = 3; n <= 6; n++) begin
      check("R5 queue order valid", 64'(rpt_valid), 1);
      check("R5 queue order key", rpt_key, nkey(4'(n)));
      @(negedge clk);
      check("R5 head held", rpt_key, nkey(4'(n)));
      pop();
    end
    check("R6 dropped key absent", 64'(rpt_valid), 0);
    send(nkey(7), 0, 0);
    check("R6 dropped key reported later", rpt_key, nkey(7));
    check("R6 valid after retry", 64'(rpt_valid), 1);
    pop();
  endtask

  task automatic t_saturate();
    logic [15:0] v;
    for (int i = 0; i < 65540; i++) send(64'h0, 1, 6'd7);
    read_hits(6'd7, v);
    check("R2 saturation", 64'(v), 16'hFFFF);
  endtask

  task automatic t_sweep();
    logic [15:0] v;
    int gap, len;
    clear_interval = 32'd40;
    while (!sweep_busy) @(negedge clk);
    repeat (2000) @(negedge clk);
    check("R8 still sweeping", 64'(sweep_busy), 1);
    send(64'h0, 1, 6'd5);
    for (int j = 0; j < 3; j++) send(nkey(9), 0, 0);
    check("R8 no report during sweep", 64'(rpt_valid), 0);
    while (sweep_busy) @(negedge clk);
    read_hits(6'd5, v);
    check("R8 query in sweep not counted", 64'(v), 0);
    read_hits(6'd7, v);
    check("R9 saturated slot cleared", 64'(v), 0);
    gap = 0;
    while (!sweep_busy) begin gap++; @(negedge clk); end
    check("R7 idle gap", 64'(gap), 40);
    clear_interval = 32'd0;
    len = 0;
    while (sweep_busy) begin len++; @(negedge clk); end
    check("R7 sweep length", 64'(len), 4096);
    repeat (100) @(negedge clk);
    check("R7 zero interval no sweep", 64'(sweep_busy), 0);
    send(nkey(1), 0, 0);
    send(nkey(1), 0, 0);
    check("R9 sketch cleared", 64'(rpt_valid), 0);
    send(nkey(1), 0, 0);
    check("R9 bloom cleared report", 64'(rpt_valid), 1);
    check("R9 key", rpt_key, nkey(1));
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_hot();
    t_queue();
    t_saturate();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule